// File: doc/BRIEF.md
# Rotating-Start Shared Bus Slot Scheduler

This block paces the shared cell bus of a multi-port cell switch. Every clock is one micro-cell slot. A bus cycle (frame) holds one slot for each pair of port position and micro-cell index, so each input port moves one whole cell per frame. Micro-cells are interleaved: all ports send their first micro-cell, then all ports send their second, and so on. A one-clock strobe marks the first slot of each frame, and the output side uses the slot-owner and micro-cell index outputs to collect the pieces.

The order in which ports take their turns is a cyclic sequence. In fixed-start mode the sequence always opens with port 0. In rotating-start mode the opening port moves up by one every frame and wraps to port 0 after the last port. Every port then leads equally often, so no port is always last in line. At each frame boundary the block samples one cell-valid bit per port. A port with no cell keeps its slots, but those slots are marked idle and are not handed to any other port.

Each port's cell-valid works with its grant as a valid/ready pair at frame granularity. The grant is the only back-pressure. A port whose valid bit was sampled high must present micro-cell `mc_idx` in each clock where its grant is high. Dropping valid during a frame does not withdraw the cell. Raising valid during a frame waits for the next boundary.

Top module: `cellbus_sched`

## Requirements
- R1: While `rst` is high, `cyc_start`, `slot_busy` and every bit of `slot_grant` are low. The first frame begins with the first rising clock edge after `rst` is released.
- R2: A frame is N_PORTS×N_MCELLS consecutive clocks (16×7 = 112 by default). In slot s of a frame, `mc_idx` equals s / N_PORTS and the sequence position is s mod N_PORTS.
- R3: At most one bit of `slot_grant` is high. Bit p is high exactly when `slot_owner` equals p and `slot_busy` is high.
- R4: `cyc_start` is high in slot 0 of every frame and low in all other slots.
- R5: When `rot_mode` was sampled as 0, the owner at sequence position k is port k.
- R6: When `rot_mode` was sampled as 1, the owner at position k is (L + k) mod N_PORTS. L is the index f mod N_PORTS of the frame, with frames counted from 0 after reset. The frame count advances every frame in either mode.
- R7: Bit p of `cell_valid` is sampled on the clock edge that begins slot 0. If it was low, every slot owned by port p in that frame shows `slot_owner` = p with `slot_busy` and `slot_grant[p]` low.
- R8: Changes to `cell_valid` or `rot_mode` made during a frame have no effect on that frame.
- R9: A port sampled valid receives exactly N_MCELLS grants per frame, with `mc_idx` stepping 0, 1, … in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock |
| rst | input | 1 | Synchronous reset, active high |
| rot_mode | input | 1 | 1 selects rotating start, 0 selects fixed start; sampled at frame boundary |
| cell_valid | input | N_PORTS | Per-port cell-present flag; sampled at frame boundary |
| cyc_start | output | 1 | High during slot 0 of each frame |
| slot_grant | output | N_PORTS | One-hot ready for the port sending in this slot |
| slot_owner | output | $clog2(N_PORTS) | Port that owns the current slot |
| slot_busy | output | 1 | The current slot carries a real micro-cell |
| mc_idx | output | $clog2(N_MCELLS) | Micro-cell index carried in the current slot |

## Verification
The bench runs many back-to-back frames and compares every slot with owner, index, busy and grant values it computes by arithmetic. The runs are fixed-start frames, rotating frames across a full wrap of the lead port, and a return to fixed then rotating mode. Those runs show that the frame count keeps advancing while fixed mode is selected. The valid masks are all ones, alternate bits, a single walking port, all zeros and a scrambled pattern. These masks separate idle marking from slot reassignment and detect an off-by-one in the owner arithmetic. In the middle of each frame the bench inverts both `cell_valid` and `rot_mode` and checks that the frame in progress keeps its settings.

// File: rtl/cellbus_pkg.sv
package cellbus_pkg;
  localparam int unsigned DEF_PORTS  = 16;
  localparam int unsigned DEF_MCELLS = 7;

  typedef enum logic {
    START_FIXED  = 1'b0,
    START_ROTATE = 1'b1
  } start_mode_e;
endpackage

// File: rtl/cellbus_slot_timer.sv
module cellbus_slot_timer #(
  parameter int unsigned N_PORTS  = cellbus_pkg::DEF_PORTS,
  parameter int unsigned N_MCELLS = cellbus_pkg::DEF_MCELLS,
  localparam int unsigned PW = (N_PORTS  > 1) ? $clog2(N_PORTS)  : 1,
  localparam int unsigned MW = (N_MCELLS > 1) ? $clog2(N_MCELLS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  output logic [PW-1:0] pos,
  output logic [MW-1:0] mc,
  output logic          frame_end,
  output logic          frame_first
);
  localparam logic [PW-1:0] POS_LAST = PW'(N_PORTS - 1);
  localparam logic [MW-1:0] MC_LAST  = MW'(N_MCELLS - 1);

  logic [PW-1:0] pos_q;
  logic [MW-1:0] mc_q;

  // Reset parks the timer on the last slot so the first edge opens a frame.
  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q <= POS_LAST;
      mc_q  <= MC_LAST;
    end else if (pos_q == POS_LAST) begin
      pos_q <= '0;
      mc_q  <= (mc_q == MC_LAST) ? '0 : mc_q + 1'b1;
    end else begin
      pos_q <= pos_q + 1'b1;
    end
  end

  assign pos         = pos_q;
  assign mc          = mc_q;
  assign frame_end   = (pos_q == POS_LAST) && (mc_q == MC_LAST);
  assign frame_first = (pos_q == '0) && (mc_q == '0);

  p_frame_len_r2: assert property (@(posedge clk) disable iff (rst)
    frame_end |=> frame_first);
  p_mc_bound_r2: assert property (@(posedge clk) disable iff (rst)
    mc_q <= MC_LAST);
  p_strobe_single_r4: assert property (@(posedge clk) disable iff (rst)
    frame_first |=> !frame_first);
endmodule

// File: rtl/cellbus_seq_gen.sv
module cellbus_seq_gen #(
  parameter int unsigned N_PORTS = cellbus_pkg::DEF_PORTS,
  localparam int unsigned PW = (N_PORTS > 1) ? $clog2(N_PORTS) : 1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          frame_end,
  input  cellbus_pkg::start_mode_e      mode,
  input  logic [N_PORTS-1:0]            valid_in,
  input  logic [PW-1:0]                 pos,
  output logic [PW-1:0]                 owner,
  output logic [N_PORTS-1:0]            mask
);
  import cellbus_pkg::*;

  localparam logic [PW-1:0] PORT_LAST = PW'(N_PORTS - 1);
  localparam logic [PW:0]   PORT_CNT  = (PW+1)'(N_PORTS);

  logic [PW-1:0]      ptr_q;    // frame counter mod N_PORTS
  logic [PW-1:0]      lead_q;   // lead port of the frame in progress
  logic [N_PORTS-1:0] mask_q;
  logic [PW:0]        sum;

  // Frame settings are captured on the edge that begins slot 0.
  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q  <= '0;
      lead_q <= '0;
      mask_q <= '0;
    end else if (frame_end) begin
      lead_q <= (mode == START_ROTATE) ? ptr_q : '0;
      ptr_q  <= (ptr_q == PORT_LAST) ? '0 : ptr_q + 1'b1;
      mask_q <= valid_in;
    end
  end

  always_comb begin
    sum   = {1'b0, lead_q} + {1'b0, pos};
    owner = (sum >= PORT_CNT) ? PW'(sum - PORT_CNT) : PW'(sum);
  end

  assign mask = mask_q;

  p_fixed_lead_r5: assert property (@(posedge clk) disable iff (rst)
    (frame_end && mode == START_FIXED) |=> (pos == '0 && owner == '0));
  p_ptr_moves_r6: assert property (@(posedge clk) disable iff (rst)
    frame_end |=> (ptr_q != $past(ptr_q) || N_PORTS == 1));
  p_frame_frozen_r8: assert property (@(posedge clk) disable iff (rst)
    !frame_end |=> ($stable(mask_q) && $stable(lead_q)));
endmodule

// File: rtl/cellbus_grant_dec.sv
module cellbus_grant_dec #(
  parameter int unsigned N_PORTS = cellbus_pkg::DEF_PORTS,
  localparam int unsigned PW = (N_PORTS > 1) ? $clog2(N_PORTS) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [PW-1:0]      owner,
  input  logic [N_PORTS-1:0] mask,
  output logic               busy,
  output logic [N_PORTS-1:0] grant
);
  assign busy = mask[owner];

  for (genvar p = 0; p < N_PORTS; p++) begin : g_port
    assign grant[p] = busy && (owner == PW'(p));
  end

  p_grant_onehot_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));
  p_busy_grant_r7: assert property (@(posedge clk) disable iff (rst)
    busy == (grant != '0));
endmodule

// File: rtl/cellbus_sched.sv
module cellbus_sched #(
  parameter int unsigned N_PORTS  = cellbus_pkg::DEF_PORTS,
  parameter int unsigned N_MCELLS = cellbus_pkg::DEF_MCELLS,
  localparam int unsigned PW = (N_PORTS  > 1) ? $clog2(N_PORTS)  : 1,
  localparam int unsigned MW = (N_MCELLS > 1) ? $clog2(N_MCELLS) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rot_mode,
  input  logic [N_PORTS-1:0] cell_valid,
  output logic               cyc_start,
  output logic [N_PORTS-1:0] slot_grant,
  output logic [PW-1:0]      slot_owner,
  output logic               slot_busy,
  output logic [MW-1:0]      mc_idx
);
  import cellbus_pkg::*;

  logic [PW-1:0]      pos;
  logic [MW-1:0]      mc;
  logic               frame_end;
  logic               frame_first;
  logic [PW-1:0]      owner;
  logic [N_PORTS-1:0] mask;
  start_mode_e        mode;

  assign mode = start_mode_e'(rot_mode);

  cellbus_slot_timer #(.N_PORTS(N_PORTS), .N_MCELLS(N_MCELLS)) u_timer (
    .clk(clk), .rst(rst), .pos(pos), .mc(mc),
    .frame_end(frame_end), .frame_first(frame_first)
  );

  cellbus_seq_gen #(.N_PORTS(N_PORTS)) u_seq (
    .clk(clk), .rst(rst), .frame_end(frame_end), .mode(mode),
    .valid_in(cell_valid), .pos(pos), .owner(owner), .mask(mask)
  );

  cellbus_grant_dec #(.N_PORTS(N_PORTS)) u_dec (
    .clk(clk), .rst(rst), .owner(owner), .mask(mask),
    .busy(slot_busy), .grant(slot_grant)
  );

  assign cyc_start  = frame_first && !rst;
  assign slot_owner = owner;
  assign mc_idx     = mc;

  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |-> (!cyc_start && !slot_busy && slot_grant == '0));
endmodule

// File: tb/test_cellbus_sched.sv
module test_cellbus_sched;
  localparam int NP = 16;
  localparam int NM = 7;
  localparam int NSLOT = NP * NM;
  localparam int NF = 40;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          rot_mode = 1'b0;
  logic [NP-1:0] cell_valid = '0;
  logic          cyc_start;
  logic [NP-1:0] slot_grant;
  logic [3:0]    slot_owner;
  logic          slot_busy;
  logic [2:0]    mc_idx;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cellbus_sched i_cellbus_sched (
    .clk(clk), .rst(rst), .rot_mode(rot_mode), .cell_valid(cell_valid),
    .cyc_start(cyc_start), .slot_grant(slot_grant), .slot_owner(slot_owner),
    .slot_busy(slot_busy), .mc_idx(mc_idx)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic mode_of(input int f);
    return !((f < 4) || (f >= 24 && f < 28));
  endfunction

  function automatic logic [NP-1:0] mask_of(input int f);
    case (f % 5)
      0: return '1;
      1: return 16'h5555;
      2: return 16'h0001 << (f % NP);
      3: return '0;
      default: return 16'(f * 32'h9E37 + 32'h1234);
    endcase
  endfunction

  initial begin
    // R1: reset state
    repeat (3) begin
      @(negedge clk);
      chk("R1 strobe", int'(cyc_start), 0);
      chk("R1 busy", int'(slot_busy), 0);
      chk("R1 grant", int'(slot_grant), 0);
    end
    rot_mode   = mode_of(0);
    cell_valid = mask_of(0);
    rst = 1'b0;
    for (int f = 0; f < NF; f++) begin
      logic          em;
      logic [NP-1:0] emask;
      int            gcnt [NP];
      em    = mode_of(f);
      emask = mask_of(f);
      for (int p = 0; p < NP; p++) gcnt[p] = 0;
      for (int s = 0; s < NSLOT; s++) begin
        int lead, own, pos, mc;
        @(negedge clk);
        pos  = s % NP;
        mc   = s / NP;
        lead = em ? (f % NP) : 0;
        own  = (lead + pos) % NP;
        chk("R4 strobe", int'(cyc_start), (s == 0) ? 1 : 0);
        chk("R2 mc_idx", int'(mc_idx), mc);
        chk(em ? "R6 owner" : "R5 owner", int'(slot_owner), own);
        chk("R7 R8 busy", int'(slot_busy), int'(emask[own]));
        chk("R3 grant", int'(slot_grant), emask[own] ? (1 << own) : 0);
        if (slot_grant[own]) begin
          chk("R9 mc order", int'(mc_idx), gcnt[own]);
          gcnt[own]++;
        end
        if (s == 50) begin
          // R8: scramble inputs mid-frame
          rot_mode   = ~em;
          cell_valid = ~emask;
        end
        if (s == NSLOT - 1) begin
          rot_mode   = mode_of(f + 1);
          cell_valid = mask_of(f + 1);
        end
      end
      for (int p = 0; p < NP; p++)
        chk("R9 grant count", gcnt[p], emask[p] ? NM : 0);
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule